// File: doc/BRIEF.md
# Interrupt Concentrator with Single Outstanding Request

The block gathers a set of level-sensitive interrupt lines and forwards at most one of them at a time. The forwarded one appears as a single asserted bit on a vector of request outputs, one output per line. The lower lines come from expansion slots and are gated in groups of four, with one mapping register per group. The upper lines come from on-board devices and each has its own mapping register. Bit 31 of a mapping register is the only writable bit and acts as the enable. The read-only bits 30:0 carry a fixed tag that software can use to identify the line.

Software reaches the block over a 32-bit register port. Through it, software enables and disables lines and acknowledges the outstanding request by writing one of two clear windows. A request stays asserted until software acknowledges it or disables its mapping register. After any mapping write, and after an acknowledge that drops the request, the block scans the asserted and enabled lines from line 0 upward and takes the first one it finds. Newly rising slot lines take over at once. Newly rising on-board lines wait until nothing is outstanding.

Top module: `irq_concentrator`

## Requirements
- R1: While and after reset, `req_o` is all zero and every enable bit reads 0. Slot map register i reads 0x7C0 | (i<<2) and on-board map register j reads 0x7E0 + j.
- R2: A write to the upper word (address bit 2 set) of a map register changes only bit 31. Bits 30:0 read back unchanged. Slot map i sits at 0xC04 + 8i and on-board map j sits at 0x1004 + 8j, with j reaching 15 at most.
- R3: The lower word of each map register pair (address bit 2 clear) reads 0, and writing it changes no enable.
- R4: The two bus-error map registers at 0x1084 and 0x108C read 0x7F0, and writes to them have no effect.
- R5: A slot line that rises while its group is enabled becomes the request on the next cycle, replacing any request already held. If several rise in the same cycle, the lowest one wins.
- R6: An on-board line that rises becomes the request only if its register is enabled and nothing is held. Otherwise the rise leaves `req_o` unchanged.
- R7: A write to the slot clear window (0x1404 + 32g) drops the held request if it lies in slot group g, and the block then rescans.
- R8: A write to the on-board clear window (0x1804 + 8j, up to 0x1860) drops the held request only if it is exactly line 32 + j, and the block then rescans. Any other index leaves `req_o` unchanged.
- R9: Every map register write is followed by a rescan. Writing enable 0 to the register that gates the held request drops that request before the rescan.
- R10: `req_o` is one-hot when a request is held and all zero otherwise.
- R11: A rescan takes the lowest-numbered line that is asserted and enabled.
- R12: Reads of any address outside the map windows return 0, and read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Interrupt input levels; 0-31 from slots, 32-63 from on-board devices |
| bus_valid_i | input | 1 | Register access strobe, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| req_o | output | 64 | Registered one-hot interrupt request vector |

## Verification
The bench builds the block with its default parameters: eight slot groups of four lines and 32 on-board lines. At this size the address windows line up exactly with the register sets. This makes the full slot map range, the sixteen reachable on-board registers and the bus-error constants observable. It also lets a single sequence set lines from both halves against each other. That covers the slot rise that pre-empts an on-board request, the on-board rise that is ignored while a request is held, and lowest-first rescans across groups after a request is dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BUS_AW = 16;
  localparam int BUS_DW = 32;

  localparam logic [15:0] SLOT_MAP_LO  = 16'h0C00;
  localparam logic [15:0] SLOT_MAP_HI  = 16'h0C3F;
  localparam logic [15:0] BOARD_MAP_LO = 16'h1000;
  localparam logic [15:0] BOARD_MAP_HI = 16'h107F;
  localparam logic [15:0] BERR_MAP_LO  = 16'h1080;
  localparam logic [15:0] BERR_MAP_HI  = 16'h108F;
  localparam logic [15:0] SLOT_CLR_LO  = 16'h1400;
  localparam logic [15:0] SLOT_CLR_HI  = 16'h14FF;
  localparam logic [15:0] BOARD_CLR_LO = 16'h1800;
  localparam logic [15:0] BOARD_CLR_HI = 16'h1860;

  localparam logic [30:0] SLOT_TAG  = 31'h7C0;
  localparam logic [30:0] BOARD_TAG = 31'h7E0;
  localparam logic [30:0] BERR_TAG  = 31'h7F0;

  typedef struct packed {
    logic       slot_map;
    logic       board_map;
    logic       slot_clr;
    logic       board_clr;
    logic       en;
    logic [7:0] idx;
  } bus_evt_t;
endpackage

// File: rtl/irqc_map_regs.sv
module irqc_map_regs
  import irqc_pkg::*;
#(
  parameter int SLOT_GRPS = 8,
  parameter int GRP_SZ    = 4,
  parameter int BOARD_N   = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                bus_valid_i,
  input  logic                                bus_we_i,
  input  logic [BUS_AW-1:0]                   bus_addr_i,
  input  logic [BUS_DW-1:0]                   bus_wdata_i,
  output logic [BUS_DW-1:0]                   bus_rdata_o,
  output bus_evt_t                            evt_o,
  output logic [SLOT_GRPS*GRP_SZ+BOARD_N-1:0] line_en_o
);
  localparam int SLOT_N = SLOT_GRPS * GRP_SZ;

  logic [SLOT_GRPS-1:0] slot_en_q, slot_en_d;
  logic [BOARD_N-1:0]   board_en_q, board_en_d;
  logic [BUS_DW-1:0]    rd_d;

  logic       in_slot_map, in_board_map, in_berr, in_slot_clr, in_board_clr;
  logic       upper;
  logic [2:0] slot_idx;
  logic [4:0] board_idx;
  logic [2:0] sclr_idx;
  logic [4:0] bclr_idx;
  logic       slot_ok, board_ok;

  assign upper        = bus_addr_i[2];
  assign in_slot_map  = bus_addr_i >= SLOT_MAP_LO  && bus_addr_i <= SLOT_MAP_HI;
  assign in_board_map = bus_addr_i >= BOARD_MAP_LO && bus_addr_i <= BOARD_MAP_HI;
  assign in_berr      = bus_addr_i >= BERR_MAP_LO  && bus_addr_i <= BERR_MAP_HI;
  assign in_slot_clr  = bus_addr_i >= SLOT_CLR_LO  && bus_addr_i <= SLOT_CLR_HI;
  assign in_board_clr = bus_addr_i >= BOARD_CLR_LO && bus_addr_i <= BOARD_CLR_HI;
  assign slot_idx     = bus_addr_i[5:3];
  assign board_idx    = bus_addr_i[7:3];
  assign sclr_idx     = bus_addr_i[7:5];
  assign bclr_idx     = bus_addr_i[7:3];
  assign slot_ok      = int'(slot_idx) < SLOT_GRPS;
  assign board_ok     = int'(board_idx) < BOARD_N;

  // write decode: only the enable bit is storage, bits 30:0 are constants
  always_comb begin
    evt_o      = '0;
    slot_en_d  = slot_en_q;
    board_en_d = board_en_q;
    if (bus_valid_i && bus_we_i && upper) begin
      if (in_slot_map && slot_ok) begin
        evt_o.slot_map      = 1'b1;
        evt_o.en            = bus_wdata_i[31];
        evt_o.idx           = 8'(slot_idx);
        slot_en_d[slot_idx] = bus_wdata_i[31];
      end else if (in_board_map && board_ok) begin
        evt_o.board_map       = 1'b1;
        evt_o.en              = bus_wdata_i[31];
        evt_o.idx             = 8'(board_idx);
        board_en_d[board_idx] = bus_wdata_i[31];
      end else if (in_slot_clr) begin
        evt_o.slot_clr = 1'b1;
        evt_o.idx      = 8'(sclr_idx);
      end else if (in_board_clr) begin
        evt_o.board_clr = 1'b1;
        evt_o.idx       = 8'(bclr_idx);
      end
    end
  end

  // enables as they stand after this cycle's write, expanded per line
  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot_en
    assign line_en_o[g] = slot_en_d[g / GRP_SZ];
  end
  for (genvar j = 0; j < BOARD_N; j++) begin : g_board_en
    assign line_en_o[SLOT_N + j] = board_en_d[j];
  end

  always_comb begin
    rd_d = '0;
    if (upper) begin
      if (in_slot_map && slot_ok)
        rd_d = {slot_en_q[slot_idx], SLOT_TAG | {26'd0, slot_idx, 2'b00}};
      else if (in_board_map && board_ok)
        rd_d = {board_en_q[board_idx], BOARD_TAG + {26'd0, board_idx}};
      else if (in_berr)
        rd_d = {1'b0, BERR_TAG};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_en_q   <= '0;
      board_en_q  <= '0;
      bus_rdata_o <= '0;
    end else begin
      slot_en_q  <= slot_en_d;
      board_en_q <= board_en_d;
      if (bus_valid_i && !bus_we_i) bus_rdata_o <= rd_d;
    end
  end

  // R3
  map_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && bus_we_i && upper) |=> ($stable(slot_en_q) && $stable(board_en_q)));
endmodule

// File: rtl/irqc_sel.sv
module irqc_sel
  import irqc_pkg::*;
#(
  parameter int SLOT_N = 32,
  parameter int GRP_SZ = 4,
  parameter int NL     = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] irq_i,
  input  logic [NL-1:0] line_en_i,
  input  bus_evt_t      evt_i,
  output logic [NL-1:0] req_o
);
  localparam int IW = $clog2(NL);
  localparam logic [NL-1:0] SLOT_MASK = {{(NL-SLOT_N){1'b0}}, {SLOT_N{1'b1}}};

  logic          held_v_q, hv;
  logic [IW-1:0] held_q, hl;
  logic [NL-1:0] lvl_q, req_d;
  logic [NL-1:0] rise, rise_slot, rise_board;
  logic [IW:0]   pick_scan, pick_slot, pick_board;
  logic          rescan;

  function automatic logic [IW:0] lowest(input logic [NL-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int k = NL - 1; k >= 0; k--)
      if (v[k]) r = {1'b1, IW'(k)};
    return r;
  endfunction

  assign rise       = irq_i & ~lvl_q & line_en_i;
  assign rise_slot  = rise & SLOT_MASK;
  assign rise_board = rise & ~SLOT_MASK;
  assign pick_scan  = lowest(irq_i & line_en_i);
  assign pick_slot  = lowest(rise_slot);
  assign pick_board = lowest(rise_board);

  // order within a cycle: bus drop, rescan, slot rise, on-board rise
  always_comb begin
    hv     = held_v_q;
    hl     = held_q;
    rescan = 1'b0;
    if (evt_i.slot_map) begin
      rescan = 1'b1;
      if (!evt_i.en && hv && int'(hl) < SLOT_N && int'(hl) / GRP_SZ == int'(evt_i.idx))
        hv = 1'b0;
    end
    if (evt_i.board_map) begin
      rescan = 1'b1;
      if (!evt_i.en && hv && int'(hl) == SLOT_N + int'(evt_i.idx)) hv = 1'b0;
    end
    if (evt_i.slot_clr && hv && int'(hl) < SLOT_N &&
        int'(hl) / GRP_SZ == int'(evt_i.idx)) begin
      hv     = 1'b0;
      rescan = 1'b1;
    end
    if (evt_i.board_clr && hv && int'(hl) == SLOT_N + int'(evt_i.idx)) begin
      hv     = 1'b0;
      rescan = 1'b1;
    end
    if (rescan && !hv) begin
      hv = pick_scan[IW];
      hl = pick_scan[IW-1:0];
    end
    if (pick_slot[IW]) begin
      hv = 1'b1;
      hl = pick_slot[IW-1:0];
    end else if (!hv && pick_board[IW]) begin
      hv = 1'b1;
      hl = pick_board[IW-1:0];
    end
    req_d = '0;
    if (hv) req_d[hl] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_v_q <= 1'b0;
      held_q   <= '0;
      lvl_q    <= '0;
      req_o    <= '0;
    end else begin
      held_v_q <= hv;
      held_q   <= hl;
      lvl_q    <= irq_i;
      req_o    <= req_d;
    end
  end

  // R10
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o));

  // R5
  slot_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rise_slot |=> |(req_o & SLOT_MASK));

  // R6
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_v_q && !(|rise_slot) && evt_i == '0) |=> $stable(req_o));
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
#(
  parameter int SLOT_GRPS = 8,
  parameter int GRP_SZ    = 4,
  parameter int BOARD_N   = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [SLOT_GRPS*GRP_SZ+BOARD_N-1:0] irq_i,
  input  logic                                bus_valid_i,
  input  logic                                bus_we_i,
  input  logic [15:0]                         bus_addr_i,
  input  logic [31:0]                         bus_wdata_i,
  output logic [31:0]                         bus_rdata_o,
  output logic [SLOT_GRPS*GRP_SZ+BOARD_N-1:0] req_o
);
  localparam int SLOT_N = SLOT_GRPS * GRP_SZ;
  localparam int NL     = SLOT_N + BOARD_N;

  bus_evt_t      evt;
  logic [NL-1:0] line_en;

  irqc_map_regs #(
    .SLOT_GRPS(SLOT_GRPS),
    .GRP_SZ   (GRP_SZ),
    .BOARD_N  (BOARD_N)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_valid_i(bus_valid_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .evt_o      (evt),
    .line_en_o  (line_en)
  );

  irqc_sel #(
    .SLOT_N(SLOT_N),
    .GRP_SZ(GRP_SZ),
    .NL    (NL)
  ) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .line_en_i(line_en),
    .evt_i    (evt),
    .req_o    (req_o)
  );
endmodule

// File: tb/sim_irq_concentrator.sv
module sim_irq_concentrator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        valid = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] req;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_concentrator u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_valid_i(valid), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .req_o(req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    irq[n] = v;
    @(negedge clk);
  endtask

  function automatic logic [63:0] bit_of(input int n);
    return 64'd1 << n;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 req after reset", req, 64'd0);
    rd(16'h0C04, d); check("R1 slot map 0", 64'(d), 64'h7C0);
    rd(16'h0C3C, d); check("R1 slot map 7", 64'(d), 64'h7DC);
    rd(16'h1004, d); check("R1 board map 0", 64'(d), 64'h7E0);
    rd(16'h107C, d); check("R1 board map 15", 64'(d), 64'h7EF);
  endtask

  task automatic t_map_write();
    logic [31:0] d;
    wr(16'h0C0C, 32'hFFFF_FFFF);
    rd(16'h0C0C, d); check("R2 slot map enable only", 64'(d), 64'h8000_07C4);
    wr(16'h1014, 32'h8000_0000);
    rd(16'h1014, d); check("R2 board map enable", 64'(d), 64'h8000_07E2);
    wr(16'h0C0C, 32'h0000_0000);
    wr(16'h1014, 32'h7FFF_FFFF);
    rd(16'h1014, d); check("R2 board map disable", 64'(d), 64'h7E2);
  endtask

  task automatic t_lower_word();
    logic [31:0] d;
    wr(16'h0C08, 32'h8000_0000);
    rd(16'h0C0C, d); check("R3 lower write ignored", 64'(d), 64'h7C4);
    rd(16'h0C08, d); check("R3 lower read zero", 64'(d), 64'd0);
    rd(16'h1010, d); check("R3 board lower read zero", 64'(d), 64'd0);
  endtask

  task automatic t_berr();
    logic [31:0] d;
    rd(16'h1084, d); check("R4 berr 0", 64'(d), 64'h7F0);
    wr(16'h108C, 32'h8000_0000);
    rd(16'h108C, d); check("R4 berr 1 read-only", 64'(d), 64'h7F0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(16'h0C04, d);
    rd(16'h2004, d); check("R12 unmapped read", 64'(d), 64'd0);
    rd(16'hF024, d); check("R12 unmapped read 2", 64'(d), 64'd0);
  endtask

  task automatic t_slot();
    wr(16'h0C14, 32'h8000_0000);
    line(9, 1'b1);  check("R5 slot rise", req, bit_of(9));
    line(10, 1'b1); check("R5 slot rise overrides", req, bit_of(10));
    line(9, 1'b0);  line(10, 1'b0);
    check("R5 request held after drop", req, bit_of(10));
    wr(16'h1424, 32'h0);  check("R7 other group clear ignored", req, bit_of(10));
    wr(16'h1444, 32'h0);  check("R7 group clear", req, 64'd0);
    wr(16'h101C, 32'h8000_0000);
    line(35, 1'b1); check("R6 board rise idle", req, bit_of(35));
    wr(16'h0C04, 32'h8000_0000);
    line(2, 1'b1);  check("R5 slot pre-empts board", req, bit_of(2));
    line(2, 1'b0);
    wr(16'h1404, 32'h0); check("R7 clear rescans to board line", req, bit_of(35));
    wr(16'h0C04, 32'h0);
    wr(16'h0C14, 32'h0);
    line(35, 1'b0);
    wr(16'h181C, 32'h0); check("R8 board clear exact", req, 64'd0);
    wr(16'h101C, 32'h0);
  endtask

  task automatic t_board();
    wr(16'h101C, 32'h8000_0000);
    wr(16'h102C, 32'h8000_0000);
    line(35, 1'b1); check("R6 board rise", req, bit_of(35));
    line(37, 1'b1); check("R6 board rise while held ignored", req, bit_of(35));
    wr(16'h182C, 32'h0); check("R8 wrong board clear ignored", req, bit_of(35));
    line(35, 1'b0);
    wr(16'h181C, 32'h0); check("R8 clear then rescan", req, bit_of(37));
    line(37, 1'b0);
    wr(16'h182C, 32'h0); check("R8 final clear", req, 64'd0);
    wr(16'h101C, 32'h0);
    wr(16'h102C, 32'h0);
  endtask

  task automatic t_prio();
    line(40, 1'b1); line(20, 1'b1); line(6, 1'b1);
    check("R9 disabled lines ignored", req, 64'd0);
    wr(16'h1044, 32'h8000_0000); check("R9 enable write rescans", req, bit_of(40));
    wr(16'h0C2C, 32'h8000_0000); check("R9 rescan keeps held", req, bit_of(40));
    wr(16'h0C0C, 32'h8000_0000); check("R9 rescan keeps held 2", req, bit_of(40));
    wr(16'h1044, 32'h0);         check("R11 disable drops, lowest first", req, bit_of(6));
    wr(16'h0C0C, 32'h0);         check("R11 next lowest", req, bit_of(20));
    wr(16'h0C2C, 32'h0);         check("R9 last disable", req, 64'd0);
    irq = '0;
    @(negedge clk);
    @(negedge clk);
    check("R10 idle after all", req, 64'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req in reset", req, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map_write();
    t_lower_word();
    t_berr();
    t_unmapped();
    t_slot();
    t_board();
    t_prio();
    summary();
  end
endmodule